// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gateable logic domain on and off in a fixed, safe order. It drives two signals toward the domain: a power-switch enable and an isolation enable. The gaps between the steps come from software-programmed delay fields counted in bus clock cycles. On the way down the domain is isolated first and its switch opened afterwards. On the way up the switch closes first and isolation is lifted only once the programmed settle time has passed.

Software drives the block over a simple synchronous register bus. It programs the two timing registers and sets the gating-enable bit. It then writes a request bit in the control register. The sequencer picks the request up on the next clock, runs it, and clears the bit itself when the last step has been taken. A busy pin and a busy bit in the control register show when a transition is in flight. Two more read-only bits in the control register mirror the switch and isolation outputs.

Top module: `pgs_power_seq`

## Requirements
- R1: After reset, `pwr_sw_en` is 1, `iso_en` is 0 and `busy` is 0. The control register reads 0x08, the gating-enable register reads 0, and both timing registers read 0x3F3F.
- R2: Register map, with every bit not listed reading 0:
  - Control register, offset 0x000: bit 0 is the power-down request, bit 1 the power-up request, bit 2 busy, bit 3 switch-on state, bit 4 isolation state.
  - Gating-enable register, offset 0x260: bit 0.
  - Power-up timing register, offset 0x264: switch delay in bits [5:0] and switch-to-isolation delay in bits [13:8].
  - Power-down timing register, offset 0x268: isolation delay in bits [5:0] and isolation-to-switch delay in bits [13:8].
  - A read returns its data on `bus_rdata` one cycle after the read is sampled. An unmapped offset reads 0.
- R3: A power-down raises `iso_en` one cycle after the request write is sampled. It drops `pwr_sw_en` after W(isolation delay) + W(isolation-to-switch delay) further cycles. The switch is never off while isolation is released.
- R4: A power-up raises `pwr_sw_en` one cycle after the request write is sampled. It drops `iso_en` after W(switch delay) + W(switch-to-isolation delay) further cycles. Isolation is never released while the switch is off.
- R5: `busy` and control bit 2 are 1 while a sequence runs. `busy` falls in the same cycle as the last output step, and the request bit that was served reads 0 afterwards.
- R6: While gating-enable bit 0 is 0, a power-down request produces no output change and no busy cycle, and its request bit reads back as 0.
- R7: When both request bits are set together, only the power-up sequence runs and the power-down request is dropped.
- R8: W(d) equals d for d from 1 to 63, and a delay field of 0 gives W(0) = 1 cycle.
- R9: Writes to the control register while `busy` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwr_sw_en | output | 1 | 1 closes the domain's power switch |
| iso_en | output | 1 | 1 clamps the domain's outputs |
| busy | output | 1 | A transition is in progress |

## Verification
Both sequences are run with several delay pairs:
- unequal non-zero fields, which show whether the two fields of one register are summed or swapped;
- all-zero fields, which separate the one-cycle floor from a skipped step;
- mixes of 0 and 63, which expose field truncation and counter wrap;
- the reset values, which confirm the 0x3F3F defaults.

Each run times the first step and the final step separately against the cycle of the write, so an added or missing pipeline stage shows up apart from a wrong delay. Directed cases cover a power-down with gating disabled, simultaneous requests, and control writes during a sequence. In each of them the outputs and the control register are read back afterwards.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int PGS_DLY_W   = 6;
    localparam int PGS_OFS_W   = 12;

    localparam logic [PGS_OFS_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [PGS_OFS_W-1:0] OFS_GATE = 12'h260;
    localparam logic [PGS_OFS_W-1:0] OFS_UPTM = 12'h264;
    localparam logic [PGS_OFS_W-1:0] OFS_DNTM = 12'h268;

    localparam logic [PGS_DLY_W-1:0] DLY_RESET = 6'h3F;

    // Bit positions inside the control register
    localparam int CB_REQ_DN = 0;
    localparam int CB_REQ_UP = 1;
    localparam int CB_BUSY   = 2;
    localparam int CB_SW     = 3;
    localparam int CB_ISO    = 4;

    // One timing register: first-step wait and second-step wait
    typedef struct packed {
        logic [PGS_DLY_W-1:0] second;
        logic [PGS_DLY_W-1:0] first;
    } seq_tm_t;

    typedef struct packed {
        logic up;
        logic dn;
    } req_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UP_SW  = 3'd1,
        ST_UP_S2I = 3'd2,
        ST_DN_ISO = 3'd3,
        ST_DN_I2S = 3'd4
    } seq_state_t;

    function automatic logic [PGS_DLY_W-1:0] wait_len(input logic [PGS_DLY_W-1:0] d);
        return (d == '0) ? PGS_DLY_W'(1) : d;
    endfunction

    // Field layout: first in [5:0], second in [13:8]
    function automatic logic [15:0] tm_pack(input seq_tm_t t);
        return {2'b00, t.second, 2'b00, t.first};
    endfunction

    function automatic seq_tm_t tm_unpack(input logic [15:0] w);
        seq_tm_t t;
        t.first  = w[PGS_DLY_W-1:0];
        t.second = w[8 +: PGS_DLY_W];
        return t;
    endfunction

endpackage

// File: rtl/pgs_delay_cnt.sv
module pgs_delay_cnt
    import pgs_pkg::*;
#(
    parameter int CNT_W = PGS_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pgs_regfile.sv
module pgs_regfile
    import pgs_pkg::*;
#(
    parameter int ADDR_W = PGS_OFS_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              sw_state,
    input  logic              iso_state,
    input  req_t              req_clr,
    output req_t              req,
    output logic              gate_en,
    output seq_tm_t           up_tm,
    output seq_tm_t           dn_tm
);

    localparam int LOW_W = (DATA_W < 16) ? DATA_W : 16;

    logic hit_ctrl, hit_gate, hit_uptm, hit_dntm;
    logic wr_en, rd_en;
    logic [15:0] wlow;
    logic [DATA_W-1:0] rd_mux;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_gate = (bus_addr == ADDR_W'(OFS_GATE));
    assign hit_uptm = (bus_addr == ADDR_W'(OFS_UPTM));
    assign hit_dntm = (bus_addr == ADDR_W'(OFS_DNTM));
    assign wr_en    = bus_sel &  bus_wr;
    assign rd_en    = bus_sel & ~bus_wr;
    assign wlow     = 16'(bus_wdata[LOW_W-1:0]);

    // Request bits: software sets them only while idle; hardware clears win
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else begin
            req_t nxt;
            nxt = req;
            if (wr_en && hit_ctrl && !busy) begin
                nxt.dn = wlow[CB_REQ_DN];
                nxt.up = wlow[CB_REQ_UP];
            end
            req <= nxt & ~req_clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_en <= 1'b0;
            up_tm   <= '{second: DLY_RESET, first: DLY_RESET};
            dn_tm   <= '{second: DLY_RESET, first: DLY_RESET};
        end else if (wr_en) begin
            if (hit_gate) gate_en <= wlow[0];
            if (hit_uptm) up_tm   <= tm_unpack(wlow);
            if (hit_dntm) dn_tm   <= tm_unpack(wlow);
        end
    end

    always_comb begin
        logic [15:0] ctrl_word;
        ctrl_word            = '0;
        ctrl_word[CB_REQ_DN] = req.dn;
        ctrl_word[CB_REQ_UP] = req.up;
        ctrl_word[CB_BUSY]   = busy;
        ctrl_word[CB_SW]     = sw_state;
        ctrl_word[CB_ISO]    = iso_state;
        rd_mux = '0;
        if (hit_ctrl)      rd_mux = DATA_W'(ctrl_word[LOW_W-1:0]);
        else if (hit_gate) rd_mux = DATA_W'(gate_en);
        else if (hit_uptm) rd_mux = DATA_W'(tm_pack(up_tm));
        else if (hit_dntm) rd_mux = DATA_W'(tm_pack(dn_tm));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
    import pgs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  req_t                 req,
    input  logic                 gate_en,
    input  seq_tm_t              up_tm,
    input  seq_tm_t              dn_tm,
    input  logic                 cnt_last,
    output logic                 cnt_load,
    output logic [PGS_DLY_W-1:0] cnt_val,
    output req_t                 req_clr,
    output logic                 pwr_sw_en,
    output logic                 iso_en,
    output logic                 busy
);

    seq_state_t state_q, state_d;
    logic start_up, start_dn, drop_dn;

    assign start_up = req.up;
    assign start_dn = req.dn & ~req.up & gate_en;
    assign drop_dn  = req.dn & (req.up | ~gate_en);
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        req_clr  = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_clr.dn = drop_dn;
                if (start_up) begin
                    state_d  = ST_UP_SW;
                    cnt_load = 1'b1;
                    cnt_val  = wait_len(up_tm.first);
                end else if (start_dn) begin
                    state_d  = ST_DN_ISO;
                    cnt_load = 1'b1;
                    cnt_val  = wait_len(dn_tm.first);
                end
            end
            ST_UP_SW: if (cnt_last) begin
                state_d  = ST_UP_S2I;
                cnt_load = 1'b1;
                cnt_val  = wait_len(up_tm.second);
            end
            ST_UP_S2I: if (cnt_last) begin
                state_d    = ST_IDLE;
                req_clr.up = 1'b1;
            end
            ST_DN_ISO: if (cnt_last) begin
                state_d  = ST_DN_I2S;
                cnt_load = 1'b1;
                cnt_val  = wait_len(dn_tm.second);
            end
            ST_DN_I2S: if (cnt_last) begin
                state_d    = ST_IDLE;
                req_clr.dn = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pwr_sw_en <= 1'b1;
            iso_en    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_up)
                pwr_sw_en <= 1'b1;
            if (state_q == ST_IDLE && start_dn)
                iso_en <= 1'b1;
            if (state_q == ST_UP_S2I && cnt_last)
                iso_en <= 1'b0;
            if (state_q == ST_DN_I2S && cnt_last)
                pwr_sw_en <= 1'b0;
        end
    end

endmodule

// File: rtl/pgs_power_seq.sv
module pgs_power_seq
    import pgs_pkg::*;
#(
    parameter int ADDR_W = PGS_OFS_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwr_sw_en,
    output logic              iso_en,
    output logic              busy
);

    req_t                 req_w, req_clr_w;
    logic                 gate_en_w;
    seq_tm_t              up_tm_w, dn_tm_w;
    logic                 cnt_load_w, cnt_last_w;
    logic [PGS_DLY_W-1:0] cnt_val_w;

    pgs_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .sw_state  (pwr_sw_en),
        .iso_state (iso_en),
        .req_clr   (req_clr_w),
        .req       (req_w),
        .gate_en   (gate_en_w),
        .up_tm     (up_tm_w),
        .dn_tm     (dn_tm_w)
    );

    pgs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req_w),
        .gate_en   (gate_en_w),
        .up_tm     (up_tm_w),
        .dn_tm     (dn_tm_w),
        .cnt_last  (cnt_last_w),
        .cnt_load  (cnt_load_w),
        .cnt_val   (cnt_val_w),
        .req_clr   (req_clr_w),
        .pwr_sw_en (pwr_sw_en),
        .iso_en    (iso_en),
        .busy      (busy)
    );

    pgs_delay_cnt #(
        .CNT_W (PGS_DLY_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load_w),
        .load_val (cnt_val_w),
        .last     (cnt_last_w)
    );

endmodule

// File: rtl/pgs_power_seq_chk.sv
module pgs_power_seq_chk
    import pgs_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pwr_sw_en,
    input logic iso_en,
    input logic busy,
    input logic gate_en,
    input req_t req
);

    // R3: switch may only be open while the domain is isolated
    p_off_needs_iso_r3: assert property (@(posedge clk) disable iff (rst)
        !pwr_sw_en |-> iso_en);

    // R4: isolation is lifted only with the switch closed
    p_release_needs_sw_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_en) |-> pwr_sw_en);

    // R5: a finished sequence leaves no request pending
    p_req_clear_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (req == '0));

    // R5: outputs stay put between sequences
    p_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(pwr_sw_en) && $stable(iso_en)));

    // R6: isolation can only start from an enabled gating bit
    p_iso_needs_gate_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(iso_en) |-> $past(gate_en));

    // R9: request bits frozen inside a running sequence
    p_ctrl_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req));

endmodule

bind pgs_power_seq pgs_power_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_sw_en (pwr_sw_en),
    .iso_en    (iso_en),
    .busy      (busy),
    .gate_en   (gate_en_w),
    .req       (req_w)
);

// File: tb/pgs_power_seq_test.sv
`timescale 1ns/1ps
module pgs_power_seq_test;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwr_sw_en, iso_en, busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pgs_power_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwr_sw_en (pwr_sw_en),
        .iso_en    (iso_en),
        .busy      (busy)
    );

    // Each entry: {iso, iso2sw, sw, sw2iso} delays, 6 bits each
    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        {6'd3,  6'd5,  6'd2,  6'd4},
        {6'd0,  6'd0,  6'd0,  6'd0},
        {6'd1,  6'd0,  6'd0,  6'd1},
        {6'd63, 6'd1,  6'd1,  6'd63},
        {6'd10, 6'd20, 6'd30, 6'd7},
        {6'd0,  6'd7,  6'd5,  6'd0}
    };

    function automatic int wl(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Starts a sequence and times its first and final output steps
    task automatic run_seq(input string tag, input bit down, input int len);
        logic pv_sw, pv_iso;
        int k_lead, k_trail, k_done;
        k_lead = -1; k_trail = -1; k_done = -1;
        pv_sw = pwr_sw_en; pv_iso = iso_en;
        bus_write(12'h000, down ? 32'h1 : 32'h2);
        for (int k = 1; k < 300 && k_done < 0; k++) begin
            @(posedge clk);
            #1;
            if (down) begin
                if (iso_en && !pv_iso && k_lead < 0) k_lead = k;
                if (!pwr_sw_en && pv_sw && k_trail < 0) k_trail = k;
            end else begin
                if (pwr_sw_en && !pv_sw && k_lead < 0) k_lead = k;
                if (!iso_en && pv_iso && k_trail < 0) k_trail = k;
            end
            if (k == 1) check({tag, " busy at start R5"}, 32'(busy), 32'h1);
            if (!busy && k_done < 0) k_done = k;
            pv_sw = pwr_sw_en; pv_iso = iso_en;
        end
        check({tag, " first step cycle"}, 32'(k_lead), 32'h1);
        check({tag, " final step cycle R8"}, 32'(k_trail), 32'(1 + len));
        check({tag, " busy end cycle R5"}, 32'(k_done), 32'(1 + len));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 sw after reset", 32'(pwr_sw_en), 32'h1);
        check("R1 iso after reset", 32'(iso_en), 32'h0);
        check("R1 busy after reset", 32'(busy), 32'h0);
        bus_read(12'h000, rd); check("R1 ctrl reset", rd, 32'h08);
        bus_read(12'h260, rd); check("R1 gate reset", rd, 32'h0);
        bus_read(12'h264, rd); check("R1 up timing reset", rd, 32'h3F3F);
        bus_read(12'h268, rd); check("R1 down timing reset", rd, 32'h3F3F);

        // R6 power-down ignored with gating disabled
        bus_write(12'h000, 32'h1);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check("R6 no busy", 32'(busy), 32'h0);
            check("R6 iso unchanged", 32'(iso_en), 32'h0);
        end
        check("R6 sw unchanged", 32'(pwr_sw_en), 32'h1);
        bus_read(12'h000, rd); check("R6 request dropped", rd, 32'h08);

        // Default timings: 63 + 63
        bus_write(12'h260, 32'h1);
        run_seq("R3 reset timing down", 1'b1, 126);
        run_seq("R4 reset timing up", 1'b0, 126);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            int di, di2s, us, us2i;
            di   = int'(VEC[v][23:18]);
            di2s = int'(VEC[v][17:12]);
            us   = int'(VEC[v][11:6]);
            us2i = int'(VEC[v][5:0]);
            bus_write(12'h268, DW'({di2s[5:0], 2'b00, di[5:0]}) & 32'h3F3F);
            bus_write(12'h264, DW'({us2i[5:0], 2'b00, us[5:0]}) & 32'h3F3F);
            bus_read(12'h268, rd);
            check("R2 down timing readback", rd, 32'((di2s << 8) | di));
            run_seq($sformatf("R3 vec%0d down", v), 1'b1, wl(di) + wl(di2s));
            check("R3 switch off at end", 32'(pwr_sw_en), 32'h0);
            bus_read(12'h000, rd); check("R5 ctrl after down", rd, 32'h10);
            run_seq($sformatf("R4 vec%0d up", v), 1'b0, wl(us) + wl(us2i));
            check("R4 iso off at end", 32'(iso_en), 32'h0);
            bus_read(12'h000, rd); check("R5 ctrl after up", rd, 32'h08);
        end

        // R2 unused bits and unmapped offset
        bus_write(12'h264, 32'hFFFF_FFFF);
        bus_read(12'h264, rd); check("R2 unused bits zero", rd, 32'h3F3F);
        bus_write(12'h260, 32'hFFFF_FFFF);
        bus_read(12'h260, rd); check("R2 gate bit only", rd, 32'h1);
        bus_read(12'h100, rd); check("R2 unmapped reads zero", rd, 32'h0);

        // R9 control write during a down sequence is ignored
        bus_write(12'h268, 32'h0505);
        bus_write(12'h000, 32'h1);
        @(posedge clk); #1;
        bus_read(12'h000, rd); check("R9 busy bit set", rd & 32'h4, 32'h4);
        bus_write(12'h000, 32'h2);
        repeat (20) @(posedge clk);
        #1;
        check("R9 still off", 32'(pwr_sw_en), 32'h0);
        check("R9 still isolated", 32'(iso_en), 32'h1);
        bus_read(12'h000, rd); check("R9 ctrl after ignored write", rd, 32'h10);

        // R7 both requests: power-up runs, down dropped
        bus_write(12'h264, 32'h0203);
        bus_write(12'h000, 32'h3);
        @(posedge clk); #1;
        check("R7 switch on first", 32'(pwr_sw_en), 32'h1);
        check("R7 still isolated", 32'(iso_en), 32'h1);
        repeat (10) @(posedge clk);
        #1;
        check("R7 up completed", 32'(iso_en), 32'h0);
        check("R7 switch stays on", 32'(pwr_sw_en), 32'h1);
        bus_read(12'h000, rd); check("R7 both requests cleared", rd, 32'h08);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule